// File: doc/BRIEF.md
# Serial Configuration Word Loader for a Frequency Synthesizer

This block takes configuration words for a frequency synthesizer over a three-wire serial link. The three wires are a serial clock, a serial data line and a load strobe. It runs on a fast system clock. Each serial wire passes through a two-flop synchronizer, and the block then detects edges on the synchronized signals. On each rising edge of the serial clock, one data bit enters a 21-bit shift register.

A rising edge on the load strobe commits the word. The two bits shifted in last form a control code, and that code picks one of three holding registers: the reference-divider setting, the feedback-divider setting or the function setting. The selected register takes the 19 upper bits of the word. The fourth code value is reserved and writes nothing.

The block also produces the charge-pump output enable and a power-down status. Both come from the chip-enable input and a power-down request bit held in the function register. The block only supplies these settings and flags to the divider, phase-detector and charge-pump logic around it.

Top module: `cfg_serial_loader`

## Requirements
- R1: The data line is sampled on each synchronized rising edge of the serial clock, most significant bit first, into a 21-bit shift register.
- R2: On a synchronized rising edge of the load strobe, the 19 upper bits of the shift register go to the register chosen by its two lowest bits, which are the last two bits shifted in. Code 00 selects the reference register, code 01 the feedback register and code 10 the function register.
- R3: A load changes at most one of the three holding registers, and the others keep their values.
- R4: A load with code 11 leaves all three holding registers unchanged.
- R5: The holding registers change only on a load-strobe rising edge. Shifting bits while the strobe is low changes none of them, and the shifted bits stay in the shift register until a later load commits them.
- R6: While chip enable is low, the power-down status is 1 and the charge-pump output enable is 0, whatever the function register holds.
- R7: While chip enable is high, the charge-pump output enable equals the inverse of function-register bit 1 (1 requests power-down). The power-down status is always the inverse of the output enable.
- R8: Reset clears all three holding registers to zero.
- R9: If more than 21 bits are shifted before a load, only the last 21 bits count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock, asynchronous |
| ser_data | input | 1 | Serial data, MSB first |
| ser_load | input | 1 | Load strobe, commits on its rising edge |
| chip_en | input | 1 | Chip enable, low forces power-down |
| ref_word | output | 19 | Reference-divider setting |
| fb_word | output | 19 | Feedback-divider setting |
| fn_word | output | 19 | Function setting; bit 1 requests power-down |
| pwr_down | output | 1 | Power-down status |
| cp_out_en | output | 1 | Charge-pump output enable |

## Verification
The assertions check on every cycle that at most one holding register changes, that a register changes only in the cycle after a detected load edge, that a reserved-code load leaves all three untouched, and that the enable flags follow chip enable. Only the bench scenarios can show that the right payload reaches the right register: bit order, routing of each code, survival of a word shifted without a load, and discarding of extra leading bits.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  localparam int WORD_W = 21;
  localparam int CTL_W  = 2;
  localparam int PAY_W  = WORD_W - CTL_W;
  localparam int NLATCH = 3;
  localparam int PD_BIT = 1;

  typedef enum logic [CTL_W-1:0] {
    CTL_REF = 2'b00,
    CTL_FB  = 2'b01,
    CTL_FN  = 2'b10,
    CTL_RSV = 2'b11
  } ctl_code_e;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;
endmodule

// File: rtl/cfg_shifter.sv
module cfg_shifter #(
  parameter int WORD_W = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              bit_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] sh_q;
  logic [WORD_W-1:0] sh_d;

  always_comb begin
    sh_d = sh_q;
    if (shift_en) sh_d = {sh_q[WORD_W-2:0], bit_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign word_o = sh_q;
endmodule

// File: rtl/cfg_latch_bank.sv
module cfg_latch_bank #(
  parameter int PAY_W  = 19,
  parameter int CTL_W  = 2,
  parameter int NLATCH = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         commit,
  input  logic [CTL_W-1:0]             code,
  input  logic [PAY_W-1:0]             payload,
  output logic [NLATCH-1:0][PAY_W-1:0] lat_o
);
  for (genvar i = 0; i < NLATCH; i++) begin : g_lat
    logic [PAY_W-1:0] lat_q;
    logic [PAY_W-1:0] lat_d;
    logic             wr_en;

    assign wr_en = commit && (code == CTL_W'(i));

    always_comb begin
      lat_d = lat_q;
      if (wr_en) lat_d = payload;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lat_q <= '0;
      else        lat_q <= lat_d;
    end

    assign lat_o[i] = lat_q;
  end
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
  import cfg_loader_pkg::*;
#(
  parameter int WORD_BITS = WORD_W,
  parameter int PD_POS    = PD_BIT
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ser_clk,
  input  logic                       ser_data,
  input  logic                       ser_load,
  input  logic                       chip_en,
  output logic [WORD_BITS-CTL_W-1:0] ref_word,
  output logic [WORD_BITS-CTL_W-1:0] fb_word,
  output logic [WORD_BITS-CTL_W-1:0] fn_word,
  output logic                       pwr_down,
  output logic                       cp_out_en
);
  localparam int PW = WORD_BITS - CTL_W;

  logic [2:0]                  sync_w;
  logic                        sclk_s, sdat_s, sld_s;
  logic                        sclk_prev_q, sld_prev_q;
  logic                        shift_en, load_rise;
  logic [WORD_BITS-1:0]        word;
  logic [CTL_W-1:0]            ctl_code;
  logic [NLATCH-1:0][PW-1:0]   lat;

  cfg_sync #(.W(3)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i({ser_load, ser_data, ser_clk}),
    .sync_o (sync_w)
  );

  assign {sld_s, sdat_s, sclk_s} = sync_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev_q <= 1'b0;
      sld_prev_q  <= 1'b0;
    end else begin
      sclk_prev_q <= sclk_s;
      sld_prev_q  <= sld_s;
    end
  end

  assign shift_en  = sclk_s & ~sclk_prev_q;
  assign load_rise = sld_s & ~sld_prev_q;

  cfg_shifter #(.WORD_W(WORD_BITS)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_en(shift_en),
    .bit_i   (sdat_s),
    .word_o  (word)
  );

  assign ctl_code = word[CTL_W-1:0];

  cfg_latch_bank #(.PAY_W(PW), .CTL_W(CTL_W), .NLATCH(NLATCH)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .commit (load_rise),
    .code   (ctl_code),
    .payload(word[WORD_BITS-1:CTL_W]),
    .lat_o  (lat)
  );

  assign ref_word  = lat[CTL_REF];
  assign fb_word   = lat[CTL_FB];
  assign fn_word   = lat[CTL_FN];
  assign cp_out_en = chip_en & ~lat[CTL_FN][PD_POS];
  assign pwr_down  = ~cp_out_en;
endmodule

// File: rtl/cfg_serial_loader_chk.sv
module cfg_serial_loader_chk #(
  parameter int PW = 19
) (
  input logic          clk,
  input logic          rst_n,
  input logic          chip_en,
  input logic          load_rise,
  input logic [1:0]    ctl_code,
  input logic [PW-1:0] ref_word,
  input logic [PW-1:0] fb_word,
  input logic [PW-1:0] fn_word,
  input logic          pwr_down,
  input logic          cp_out_en
);
  logic [PW-1:0] ref_p, fb_p, fn_p;
  logic          rise_p;
  logic [1:0]    code_p;
  logic [2:0]    chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_p  <= '0;
      fb_p   <= '0;
      fn_p   <= '0;
      rise_p <= 1'b0;
      code_p <= '0;
    end else begin
      ref_p  <= ref_word;
      fb_p   <= fb_word;
      fn_p   <= fn_word;
      rise_p <= load_rise;
      code_p <= ctl_code;
    end
  end

  assign chg = {fn_word != fn_p, fb_word != fb_p, ref_word != ref_p};

  p_single_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chg));

  p_change_needs_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|chg) |-> rise_p);

  p_reserved_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_p && code_p == 2'b11) |-> (chg == 3'b000));

  p_chip_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_en |-> (pwr_down && !cp_out_en));

  p_flags_opposite_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down != cp_out_en);
endmodule

bind cfg_serial_loader cfg_serial_loader_chk #(.PW(PW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .chip_en  (chip_en),
  .load_rise(load_rise),
  .ctl_code (ctl_code),
  .ref_word (ref_word),
  .fb_word  (fb_word),
  .fn_word  (fn_word),
  .pwr_down (pwr_down),
  .cp_out_en(cp_out_en)
);

// File: tb/cfg_serial_loader_test.sv
module cfg_serial_loader_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ser_clk, ser_data, ser_load, chip_en;
  logic [18:0] ref_word, fb_word, fn_word;
  logic        pwr_down, cp_out_en;

  int checks = 0;
  int errors = 0;
  logic [18:0] m_ref, m_fb, m_fn;

  always #10 clk = ~clk;

  cfg_serial_loader uut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_load(ser_load), .chip_en(chip_en), .ref_word(ref_word),
    .fb_word(fb_word), .fn_word(fn_word), .pwr_down(pwr_down),
    .cp_out_en(cp_out_en)
  );

  task automatic chk(string req, logic [18:0] act, logic [18:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_all(string req);
    chk({req, " ref"}, ref_word, m_ref);
    chk({req, " fb"},  fb_word,  m_fb);
    chk({req, " fn"},  fn_word,  m_fn);
  endtask

  task automatic shift_bits(logic [31:0] v, int n);
    for (int i = n - 1; i >= 0; i--) begin
      ser_data = v[i];
      #100 ser_clk = 1'b1;
      #100 ser_clk = 1'b0;
    end
  endtask

  task automatic pulse_load();
    #100 ser_load = 1'b1;
    #100 ser_load = 1'b0;
    #200;
  endtask

  task automatic model(logic [20:0] w);
    case (w[1:0])
      2'b00: m_ref = w[20:2];
      2'b01: m_fb  = w[20:2];
      2'b10: m_fn  = w[20:2];
      default: ;
    endcase
  endtask

  task automatic t_reset();
    m_ref = '0; m_fb = '0; m_fn = '0;
    chk_all("R8 reset");
    chk("R7 reset cp_out_en", 19'(cp_out_en), 19'd1);
  endtask

  task automatic t_each_code();
    logic [20:0] w;
    w = {19'h5A5A5, 2'b00}; shift_bits(32'(w), 21); pulse_load(); model(w); chk_all("R1 R2 code00");
    w = {19'h12345, 2'b01}; shift_bits(32'(w), 21); pulse_load(); model(w); chk_all("R2 code01");
    w = {19'h40001, 2'b10}; shift_bits(32'(w), 21); pulse_load(); model(w); chk_all("R2 code10");
  endtask

  task automatic t_random();
    for (int k = 0; k < 12; k++) begin
      logic [20:0] w;
      w = 21'($urandom);
      w[4] = 1'b0;
      shift_bits(32'(w), 21); pulse_load(); model(w);
      chk_all("R3 random single target");
    end
  endtask

  task automatic t_reserved();
    shift_bits(32'({19'h7FFFF, 2'b11}), 21); pulse_load();
    chk_all("R4 reserved code");
  endtask

  task automatic t_no_load();
    logic [20:0] w;
    w = {19'h0ACE1, 2'b01};
    shift_bits(32'(w), 21); #400;
    chk_all("R5 shift without load");
    pulse_load(); model(w);
    chk_all("R5 deferred commit");
  endtask

  task automatic t_long();
    logic [20:0] w;
    w = {19'h3C3C3, 2'b00};
    shift_bits(32'hF, 4);
    shift_bits(32'(w), 21); pulse_load(); model(w);
    chk_all("R9 extra leading bits");
  endtask

  task automatic t_power();
    logic [20:0] w;
    w = {19'h00002, 2'b10};
    shift_bits(32'(w), 21); pulse_load(); model(w);
    chk("R7 pd bit set cp_out_en", 19'(cp_out_en), 19'd0);
    chk("R7 pd bit set pwr_down", 19'(pwr_down), 19'd1);
    w = {19'h00000, 2'b10};
    shift_bits(32'(w), 21); pulse_load(); model(w);
    chk("R7 pd bit clear cp_out_en", 19'(cp_out_en), 19'd1);
    chk("R7 pd bit clear pwr_down", 19'(pwr_down), 19'd0);
    chip_en = 1'b0; #100;
    chk("R6 chip off cp_out_en", 19'(cp_out_en), 19'd0);
    chk("R6 chip off pwr_down", 19'(pwr_down), 19'd1);
    chip_en = 1'b1; #100;
    chk("R7 chip back on", 19'(cp_out_en), 19'd1);
  endtask

  initial begin
    rst_n = 1'b0; ser_clk = 1'b0; ser_data = 1'b0; ser_load = 1'b0; chip_en = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_each_code();
    t_random();
    t_reserved();
    t_no_load();
    t_long();
    t_power();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #3_000_000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule